// File: doc/BRIEF.md
# Page Write Buffer and Write-Cycle Controller

This block sits behind a two-wire serial slave front end and in front of a byte-wide memory array. The front end hands it events that it has already decoded: a START, a starting address, one strobe per received data byte, and a STOP tagged with the clock slot of the byte frame in which it was seen. The block holds the data bytes of one write transaction in a page-sized latch set. Each byte goes in at a running in-page offset. The page number comes from the starting address and stays fixed for the whole transaction.

At STOP the block decides whether the latched bytes are committed. A commit needs three things: the STOP falls in the slot right after an acknowledge, the write-protect input is low, and at least one byte has been latched. If all three hold, the block enters a timed internal write cycle of a programmable number of clocks. During that cycle it raises busy, ignores every event input, and drains the latched bytes to the array, one write per latched offset. Any other outcome drops the latched bytes without writing. A single byte write is just a page write of length one.

Top module: `page_commit_ctrl`

## Requirements
- R1: After synchronous reset, `busy_o` and `mem_we_o` are low.
- R2: `addr_i` splits into two fields: bits [5:0] are the in-page offset and the bits above them are the page number. `addr_load_i` loads both fields. Each accepted `byte_wr_i` latches `byte_i` at the current offset and then moves the offset up by one. The offset wraps inside the low six bits and the page number does not change.
- R3: Once more than 64 bytes have arrived in one transaction, each later byte replaces the byte held at the same offset. The last byte written at an offset is the one that gets committed.
- R4: A commit happens when `stop_i` is sampled with `stop_slot_i` equal to 10 (the slot after the acknowledge), with `wp_i` low and at least one byte latched. `busy_o` rises on the next cycle and stays high for exactly `WC_CYCLES` cycles.
- R5: During the write cycle, `mem_we_o` pulses exactly once for each latched offset. Each pulse carries `mem_addr_o` = {page, offset} and the last byte latched there. Offsets that were not latched are not written, and `mem_we_o` is high only while `busy_o` is high.
- R6: If `wp_i` is high when a STOP is sampled, no write cycle starts, `busy_o` stays low and the latched bytes are dropped.
- R7: A STOP with `stop_slot_i` other than 10 starts no write cycle and drops the latched bytes.
- R8: A `start_i` pulse drops the latched bytes. A following STOP at slot 10 then starts no write cycle.
- R9: A STOP at slot 10 with no byte latched (an address-only write) starts no write cycle.
- R10: While `busy_o` is high, `start_i`, `addr_load_i`, `byte_wr_i` and `stop_i` have no effect. All latched bytes are cleared when `busy_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_i | input | 1 | Write-protect level, sampled at STOP |
| start_i | input | 1 | START event pulse |
| addr_load_i | input | 1 | Load starting address |
| addr_i | input | ADDR_W | Starting address: {page, offset} |
| byte_wr_i | input | 1 | Data byte strobe |
| byte_i | input | DATA_W | Data byte |
| stop_i | input | 1 | STOP event pulse |
| stop_slot_i | input | 4 | Clock slot of the byte frame in which STOP occurred |
| busy_o | output | 1 | Internal write cycle in progress |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_data_o | output | DATA_W | Array write data |

## Verification
The bench targets four areas.

- **Offset wrap.** A transaction starts at offset 62 and runs past the page end. A design that carried the overflow into the page bits would write into the next page.
- **Overflow.** A 66-byte run checks that the first two offsets end up holding the final bytes and that exactly 64 writes occur. A design without per-offset flags would write stale or duplicate bytes.
- **Dropped transactions.** A wrong-slot STOP, a START, or write protect must each leave the latches empty. The bench proves this by following with a slot-10 STOP, which must start nothing. A design that only suppressed the first STOP would commit on the second.
- **Activity during busy.** The bench injects every event during a cycle. It then checks that the busy length is unchanged and that a later STOP finds nothing to commit. A design that restarted its timer, or left flags set after busy, would fail.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int unsigned SLOT_W = 4;
  // slot right after the acknowledge (tenth clock of a byte frame)
  localparam logic [SLOT_W-1:0] COMMIT_SLOT = 4'd10;
endpackage

// File: rtl/pwb_latch.sv
module pwb_latch #(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PAGE_BYTES = 64,
  localparam int unsigned OFFS_W    = $clog2(PAGE_BYTES),
  localparam int unsigned PAGE_W    = ADDR_W - OFFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_wr_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              drop_i,
  input  logic [OFFS_W-1:0] rd_idx_i,
  output logic [PAGE_W-1:0] page_o,
  output logic              any_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_flag_o
);
  logic [DATA_W-1:0]     lat_mem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] flag_q;
  logic [OFFS_W-1:0]     offs_q;
  logic [PAGE_W-1:0]     page_q;
  logic                  wr_en;

  assign wr_en = accept_i && byte_wr_i;

  // byte storage: one write port, registered read port (RAM-inferable)
  always_ff @(posedge clk) begin
    if (wr_en) lat_mem[offs_q] <= byte_i;
    rd_data_o <= lat_mem[rd_idx_i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q    <= '0;
      offs_q    <= '0;
      page_q    <= '0;
      rd_flag_o <= 1'b0;
    end else begin
      rd_flag_o <= flag_q[rd_idx_i];
      if (drop_i)      flag_q         <= '0;
      else if (wr_en)  flag_q[offs_q] <= 1'b1;
      if (accept_i && addr_load_i) begin
        offs_q <= addr_i[OFFS_W-1:0];
        page_q <= addr_i[ADDR_W-1:OFFS_W];
      end else if (wr_en) begin
        offs_q <= offs_q + 1'b1;
      end
    end
  end

  assign page_o = page_q;
  assign any_o  = |flag_q;

  // R2
  offs_step_chk: assert property (@(posedge clk) disable iff (rst)
    (accept_i && byte_wr_i && !addr_load_i) |=> (offs_q == OFFS_W'($past(offs_q) + 1'b1)));
  // R8
  drop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    drop_i |=> !any_o);
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
  parameter int unsigned WC_CYCLES = 1_000_000,
  localparam int unsigned CNT_W    = $clog2(WC_CYCLES)
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  output logic busy_o,
  output logic done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WC_CYCLES - 1);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = busy_o && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_o) begin
      if (go_i) begin
        busy_o <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (done_o) begin
      busy_o <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_o) |=> (busy_o && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/pwb_drain.sv
module pwb_drain #(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PAGE_BYTES = 64,
  localparam int unsigned OFFS_W    = $clog2(PAGE_BYTES),
  localparam int unsigned PAGE_W    = ADDR_W - OFFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_flag_i,
  output logic [OFFS_W-1:0] rd_idx_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o
);
  localparam logic [OFFS_W-1:0] IDX_LAST = OFFS_W'(PAGE_BYTES - 1);
  logic              scan_q, scan_d1;
  logic [OFFS_W-1:0] idx_q, idx_d1;

  assign rd_idx_o = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_q   <= 1'b0;
      scan_d1  <= 1'b0;
      idx_q    <= '0;
      idx_d1   <= '0;
      mem_we_o <= 1'b0;
    end else begin
      scan_d1  <= scan_q;
      idx_d1   <= idx_q;
      mem_we_o <= scan_d1 && rd_flag_i;
      if (go_i) begin
        scan_q <= 1'b1;
        idx_q  <= '0;
      end else if (scan_q) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == IDX_LAST) scan_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    mem_addr_o <= {page_i, idx_d1};
    mem_data_o <= rd_data_i;
  end

  // R10
  scan_no_go_chk: assert property (@(posedge clk) disable iff (rst)
    scan_q |-> !go_i);
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl #(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PAGE_BYTES = 64,
  parameter int unsigned WC_CYCLES  = 1_000_000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wp_i,
  input  logic                       start_i,
  input  logic                       addr_load_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       byte_wr_i,
  input  logic [DATA_W-1:0]          byte_i,
  input  logic                       stop_i,
  input  logic [pwb_pkg::SLOT_W-1:0] stop_slot_i,
  output logic                       busy_o,
  output logic                       mem_we_o,
  output logic [ADDR_W-1:0]          mem_addr_o,
  output logic [DATA_W-1:0]          mem_data_o
);
  import pwb_pkg::*;
  localparam int unsigned OFFS_W = $clog2(PAGE_BYTES);
  localparam int unsigned PAGE_W = ADDR_W - OFFS_W;

  logic              accept, stop_ok, go, drop, done, any_valid, rd_flag;
  logic [PAGE_W-1:0] page;
  logic [OFFS_W-1:0] rd_idx;
  logic [DATA_W-1:0] rd_data;

  assign accept  = !busy_o;
  assign stop_ok = stop_i && (stop_slot_i == COMMIT_SLOT) && !wp_i && any_valid;
  assign go      = accept && stop_ok;
  assign drop    = done || (accept && (start_i || (stop_i && !stop_ok)));

  pwb_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_latch (
    .clk(clk), .rst(rst), .accept_i(accept),
    .addr_load_i(addr_load_i), .addr_i(addr_i),
    .byte_wr_i(byte_wr_i), .byte_i(byte_i), .drop_i(drop),
    .rd_idx_i(rd_idx), .page_o(page), .any_o(any_valid),
    .rd_data_o(rd_data), .rd_flag_o(rd_flag)
  );

  pwb_timer #(.WC_CYCLES(WC_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .go_i(go), .busy_o(busy_o), .done_o(done)
  );

  pwb_drain #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_drain (
    .clk(clk), .rst(rst), .go_i(go), .page_i(page),
    .rd_data_i(rd_data), .rd_flag_i(rd_flag), .rd_idx_o(rd_idx),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o)
  );

  // R5
  we_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> busy_o);
  // R4
  commit_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(stop_i && stop_slot_i == COMMIT_SLOT && !wp_i));
  // R6
  wp_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && stop_i && wp_i) |=> !busy_o);
  // R9
  empty_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !any_valid) |=> !busy_o);
  // R10
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> $stable(page));
endmodule

// File: tb/page_commit_ctrl_test.sv
module page_commit_ctrl_test;
  localparam int unsigned AW = 15;
  localparam int unsigned WC = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wp = 1'b0, start = 1'b0, aload = 1'b0, bwr = 1'b0, stop = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    bdat = '0;
  logic [3:0]    slot = '0;
  logic          busy, we;
  logic [AW-1:0] maddr;
  logic [7:0]    mdata;

  int checks = 0, fails = 0, wr_count = 0;
  logic [7:0] exp_d [64];
  logic       exp_v [64];
  logic [8:0] exp_page;
  logic [5:0] cur_off;

  always #5 clk = ~clk;

  page_commit_ctrl #(.ADDR_W(AW), .DATA_W(8), .PAGE_BYTES(64), .WC_CYCLES(WC)) uut (
    .clk(clk), .rst(rst), .wp_i(wp), .start_i(start), .addr_load_i(aload),
    .addr_i(addr), .byte_wr_i(bwr), .byte_i(bdat), .stop_i(stop),
    .stop_slot_i(slot), .busy_o(busy), .mem_we_o(we),
    .mem_addr_o(maddr), .mem_data_o(mdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // array-side monitor: every write must match the bench model (R5)
  always @(negedge clk) begin
    if (!rst && we) begin
      wr_count++;
      check(maddr[14:6] == exp_page, "R5 page", int'(maddr[14:6]), int'(exp_page));
      check(exp_v[maddr[5:0]] == 1'b1, "R5 offset latched", int'(maddr[5:0]), 1);
      check(mdata == exp_d[maddr[5:0]], "R5 data", int'(mdata), int'(exp_d[maddr[5:0]]));
    end
  end

  task automatic clear_model();
    for (int i = 0; i < 64; i++) begin exp_v[i] = 1'b0; exp_d[i] = '0; end
  endtask

  task automatic send_addr(input logic [AW-1:0] a);
    @(negedge clk); addr = a; aload = 1'b1;
    @(negedge clk); aload = 1'b0;
    exp_page = a[14:6]; cur_off = a[5:0];
  endtask

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk); bdat = d; bwr = 1'b1;
    @(negedge clk); bwr = 1'b0;
    exp_d[cur_off] = d; exp_v[cur_off] = 1'b1; cur_off = cur_off + 1'b1;
  endtask

  task automatic send_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send_stop(input logic [3:0] s);
    wr_count = 0;
    @(negedge clk); stop = 1'b1; slot = s;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic expect_cycle(input int base, input string req);
    int n = base;
    int nexp = 0;
    for (int i = 0; i < 64; i++) if (exp_v[i]) nexp++;
    while (busy && n < 4 * WC) begin n++; @(negedge clk); end
    repeat (4) @(negedge clk);
    check(n == WC, {req, " busy length"}, n, WC);
    check(wr_count == nexp, {req, " write count"}, wr_count, nexp);
  endtask

  task automatic expect_idle(input string req);
    int hi = 0;
    repeat (10) begin if (busy) hi++; @(negedge clk); end
    check(hi == 0, {req, " busy stays low"}, hi, 0);
    check(wr_count == 0, {req, " no array write"}, wr_count, 0);
  endtask

  task automatic t_reset();
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(we == 1'b0, "R1 we after reset", int'(we), 0);
  endtask

  task automatic t_byte_write();  // R4, R5
    clear_model();
    send_addr(15'h1234); send_byte(8'hA5);
    send_stop(4'd10);
    check(busy == 1'b1, "R4 busy after commit", int'(busy), 1);
    expect_cycle(0, "R4");
  endtask

  task automatic t_page_wrap();  // R2
    clear_model();
    send_addr(15'h0A3E);
    for (int i = 0; i < 5; i++) send_byte(8'h10 + 8'(i));
    send_stop(4'd10);
    expect_cycle(0, "R2");
  endtask

  task automatic t_overflow();  // R3
    clear_model();
    send_addr(15'h7FC0);
    for (int i = 0; i < 66; i++) send_byte(8'(i) ^ 8'h5A);
    send_stop(4'd10);
    expect_cycle(0, "R3");
  endtask

  task automatic t_wp();  // R6
    clear_model();
    wp = 1'b1;
    send_addr(15'h0100); send_byte(8'h11); send_byte(8'h22);
    send_stop(4'd10);
    expect_idle("R6");
    wp = 1'b0;
    send_stop(4'd10);
    expect_idle("R6 dropped");
  endtask

  task automatic t_bad_slot();  // R7
    clear_model();
    send_addr(15'h0200); send_byte(8'h33);
    send_stop(4'd9);
    expect_idle("R7");
    send_stop(4'd10);
    expect_idle("R7 dropped");
  endtask

  task automatic t_start_drop();  // R8
    clear_model();
    send_addr(15'h0300); send_byte(8'h44); send_byte(8'h55);
    send_start();
    send_stop(4'd10);
    expect_idle("R8");
  endtask

  task automatic t_empty();  // R9
    clear_model();
    send_addr(15'h0400);
    send_stop(4'd10);
    expect_idle("R9");
  endtask

  task automatic t_busy_ignore();  // R10
    clear_model();
    send_addr(15'h0540); send_byte(8'h77);
    send_stop(4'd10);
    addr = 15'h7FFF; aload = 1'b1; bdat = 8'hEE; bwr = 1'b1;
    stop = 1'b1; slot = 4'd10; start = 1'b1;
    @(negedge clk);
    aload = 1'b0; bwr = 1'b0; stop = 1'b0; start = 1'b0;
    expect_cycle(1, "R10");
    send_stop(4'd10);
    expect_idle("R10 flags cleared");
  endtask

  initial begin
    clear_model();
    exp_page = '0; cur_off = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_byte_write();
    t_page_wrap();
    t_overflow();
    t_wp();
    t_bad_slot();
    t_start_drop();
    t_empty();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule